// File: doc/BRIEF.md
# Dual-Oscillator Clock Switch Controller

This block chooses the system clock of a small microcontroller. There are two sources: a 32.768 kHz low-speed clock and a 4 MHz high-speed clock. Software holds two request bits. The first switches the high-speed oscillator on or off. The second picks which source drives the system clock. The block does not let software move the multiplexer freely. It enforces a safe order in hardware:

- On the way up, the oscillator is switched on, the block waits a fixed stabilization time counted on the low-speed clock, and only then is the fast source selected.
- On the way down, the multiplexer returns to the slow source first, and only then may the oscillator be switched off.

Requests that arrive out of order are not refused. They are held pending or deferred and then completed automatically. Status outputs show whether the fast oscillator is ready and which clock is actually in use.

The selected clock goes through a glitch-free multiplexer built from two flops per clock domain, cross-coupled. The block also produces an instruction-cycle strobe from the selected clock. One instruction cycle equals two system-clock periods: about 61 µs on the slow source and 0.5 µs on the fast one. The request bits are assumed to be written synchronously to the low-speed clock.

Top module: `dual_osc_clk_switch`

## Requirements
- R1: After reset, `hf_osc_en`, `hf_ready` and `hf_active` are 0, and `sys_clk` follows `lf_clk`.
- R2: When `hf_en_req` = 1 (1 = oscillator on, 0 = off) is sampled at an `lf_clk` rising edge, `hf_osc_en` reads 1 after that same edge.
- R3: `hf_ready` first reads 1 after the (STAB_CYCLES+1)-th `lf_clk` rising edge, counted from and including the edge that turned `hf_osc_en` on. With the default STAB_CYCLES = 164, that is the 165th edge. This gives at least 164 slow cycles (≥ 5 ms) of running oscillator before it is ready.
- R4: When `hf_osc_en` drops, the stabilization count clears and `hf_ready` reads 0. A later enable restarts the full count of R3.
- R5: `hf_sel_req` = 1 selects the fast clock and 0 the slow clock. A fast selection is held pending while `hf_en_req` is 0 or `hf_ready` is 0, so `hf_active` stays 0. Once ready, `hf_active` becomes 1 within 8 `lf_clk` cycles without further software action.
- R6: While `hf_active` = 1, `sys_clk` follows `hf_clk`. While it is 0 and the switch has settled, `sys_clk` follows `lf_clk`.
- R7: `sys_clk` never shows a high or low pulse shorter than half a period of the faster source, including during switches.
- R8: Clearing `hf_sel_req` while `hf_en_req` stays 1 returns `hf_active` to 0 within 8 `lf_clk` cycles, and `hf_osc_en` and `hf_ready` stay 1.
- R9: Clearing `hf_en_req` while the fast clock is in use is deferred. `hf_osc_en` stays 1 until the multiplexer has moved back to the slow clock, then falls. `hf_osc_en` is never 0 while the fast branch drives `sys_clk`.
- R10: Clearing `hf_en_req` while the slow clock is in use makes `hf_osc_en` read 0 after the next `lf_clk` rising edge.
- R11: `cyc_stb` toggles on every rising edge of `sys_clk`. Its rising edges are therefore spaced two system-clock periods apart: 16 ns on the bench's fast clock and 128 ns on its slow clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_clk | input | 1 | Low-speed source clock (32.768 kHz in use) |
| hf_clk | input | 1 | High-speed source clock, free running |
| hf_en_req | input | 1 | Software request: 1 = fast oscillator on |
| hf_sel_req | input | 1 | Software request: 1 = fast clock, 0 = slow clock |
| hf_osc_en | output | 1 | Enable to the fast oscillator |
| hf_ready | output | 1 | Stabilization time has elapsed |
| hf_active | output | 1 | Fast clock is actually driving sys_clk (slow-domain view) |
| sys_clk | output | 1 | Glitch-free selected system clock |
| cyc_stb | output | 1 | Instruction-cycle strobe, toggles per sys_clk cycle |

## Verification
The results of the slow-domain control settle at known edges:

- `hf_osc_en` changes one `lf_clk` edge after a request.
- `hf_ready` rises on exactly the 165th edge.

The bench drives requests on falling edges of `lf_clk` and samples each result on the next falling edge, which is half a period after the edge that must produce it. Multiplexer hand-overs cross clock domains, so their latency varies. For these the bench polls once per slow cycle against an upper bound of 8 cycles. Pulse widths, the oscillator hold-off and early selection are checked continuously by monitors. Source tracking is sampled 2 ns or 10 ns after each source edge.

// File: rtl/dual_osc_clk_switch.sv
module dual_osc_clk_switch #(
  parameter int STAB_CYCLES = 164
) (
  input  logic rst_n,
  input  logic lf_clk,
  input  logic hf_clk,
  input  logic hf_en_req,
  input  logic hf_sel_req,
  output logic hf_osc_en,
  output logic hf_ready,
  output logic hf_active,
  output logic sys_clk,
  output logic cyc_stb
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYCLES);

  logic [CW-1:0] stab_cnt;
  logic osc_nx, sel_q;
  logic lf_g1, lf_g2, hf_g1, hf_g2;
  logic act_s1, act_s2, phase;

  assign hf_ready  = (stab_cnt == STAB_LAST);
  assign hf_active = act_s2;
  assign osc_nx    = hf_en_req | sel_q | act_s2;

  always_ff @(posedge lf_clk or negedge rst_n)
    if (!rst_n) begin
      hf_osc_en <= 1'b0;
      stab_cnt  <= '0;
      sel_q     <= 1'b0;
      act_s1    <= 1'b0;
      act_s2    <= 1'b0;
    end else begin
      hf_osc_en <= osc_nx;
      if (!osc_nx)
        stab_cnt <= '0;
      else if (hf_osc_en && !hf_ready)
        stab_cnt <= stab_cnt + CW'(1);
      sel_q  <= hf_sel_req & hf_en_req & hf_ready & hf_osc_en;
      act_s1 <= hf_g2;
      act_s2 <= act_s1;
    end

  always_ff @(posedge lf_clk or negedge rst_n)
    if (!rst_n) lf_g1 <= 1'b1;
    else        lf_g1 <= ~sel_q & ~hf_g2;

  always_ff @(negedge lf_clk or negedge rst_n)
    if (!rst_n) lf_g2 <= 1'b1;
    else        lf_g2 <= lf_g1;

  always_ff @(posedge hf_clk or negedge rst_n)
    if (!rst_n) hf_g1 <= 1'b0;
    else        hf_g1 <= sel_q & ~lf_g2;

  always_ff @(negedge hf_clk or negedge rst_n)
    if (!rst_n) hf_g2 <= 1'b0;
    else        hf_g2 <= hf_g1;

  assign sys_clk = (lf_clk & lf_g2) | (hf_clk & hf_g2);

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;

  assign cyc_stb = phase;

  assert_osc_held_R9: assert property (@(posedge hf_clk) disable iff (!rst_n)
    hf_g2 |-> hf_osc_en) else $error("fast branch live with oscillator off");

  assert_ready_first_R5: assert property (@(posedge lf_clk) disable iff (!rst_n)
    hf_active |-> hf_ready) else $error("fast clock in use before ready");

  assert_cnt_bound_R3: assert property (@(posedge lf_clk) disable iff (!rst_n)
    stab_cnt <= STAB_LAST) else $error("stabilization count overran");

  assert_cnt_clear_R4: assert property (@(posedge lf_clk) disable iff (!rst_n)
    !hf_osc_en |-> stab_cnt == '0) else $error("count not cleared while off");

  assert_one_branch_R7: assert property (@(posedge hf_clk) disable iff (!rst_n)
    !(lf_g2 && hf_g2)) else $error("both mux branches enabled");

  assert_off_next_R10: assert property (@(posedge lf_clk) disable iff (!rst_n)
    (!hf_en_req && !sel_q && !act_s2) |=> !hf_osc_en) else $error("oscillator not released");
endmodule

// File: tb/dual_osc_clk_switch_tb.sv
`timescale 1ns/1ps
module dual_osc_clk_switch_tb;
  localparam int STAB = 164;

  logic rst_n = 1'b0, lf_clk = 1'b0, hf_clk = 1'b0;
  logic hf_en_req = 1'b0, hf_sel_req = 1'b0;
  logic hf_osc_en, hf_ready, hf_active, sys_clk, cyc_stb;

  int n_chk = 0, n_bad = 0;
  int glitches = 0, osc_viol = 0, early = 0, en_cnt = 0;
  bit mon_on = 1'b0;
  realtime last_edge = 0.0;

  dual_osc_clk_switch #(.STAB_CYCLES(STAB)) u_dut (
    .rst_n(rst_n), .lf_clk(lf_clk), .hf_clk(hf_clk),
    .hf_en_req(hf_en_req), .hf_sel_req(hf_sel_req),
    .hf_osc_en(hf_osc_en), .hf_ready(hf_ready), .hf_active(hf_active),
    .sys_clk(sys_clk), .cyc_stb(cyc_stb));

  initial begin #1; forever #4 hf_clk = ~hf_clk; end
  initial forever #32 lf_clk = ~lf_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge lf_clk);
  endtask

  task automatic track(input bit fast, input string req);
    int miss = 0;
    for (int i = 0; i < 8; i++) begin
      if (fast) begin
        @(posedge hf_clk); #2; if (sys_clk !== 1'b1) miss++;
        @(negedge hf_clk); #2; if (sys_clk !== 1'b0) miss++;
      end else begin
        @(posedge lf_clk); #10; if (sys_clk !== 1'b1) miss++;
        @(negedge lf_clk); #10; if (sys_clk !== 1'b0) miss++;
      end
    end
    chk(miss == 0, req, fast ? "sys_clk tracks hf_clk" : "sys_clk tracks lf_clk", miss, 0);
  endtask

  task automatic strobe(input int exp_ns, input string req);
    realtime t0, t1;
    @(posedge cyc_stb); t0 = $realtime;
    @(posedge cyc_stb); t1 = $realtime;
    chk(int'(t1 - t0) == exp_ns, req, "strobe spacing ns", int'(t1 - t0), exp_ns);
  endtask

  task automatic wait_ready(input string req);
    int first = 0;
    step(1);
    chk(hf_osc_en === 1'b1, "R2", "osc enable after first edge", hf_osc_en, 1);
    for (int k = 2; k <= 300; k++) begin
      step(1);
      if (hf_ready === 1'b1) begin first = k; break; end
    end
    chk(first == STAB + 1, req, "edge of first ready", first, STAB + 1);
  endtask

  task automatic wait_active(input bit val, input string req);
    int n = 0;
    while (hf_active !== val && n < 8) begin step(1); n++; end
    chk(hf_active === val, req, "hf_active settles within 8", hf_active, val);
  endtask

  always @(sys_clk) if (mon_on) begin
    if ($realtime - last_edge < 3.99) glitches++;
    last_edge = $realtime;
  end

  always @(negedge lf_clk) if (mon_on) begin
    if (hf_active && !hf_osc_en) osc_viol++;
    if (!hf_osc_en) en_cnt = 0; else en_cnt++;
    if (hf_active && en_cnt < STAB) early++;
  end

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3); #6; rst_n = 1'b1;
    last_edge = $realtime; mon_on = 1'b1;
    step(1);
    chk(hf_osc_en === 1'b0, "R1", "osc enable at reset", hf_osc_en, 0);
    chk(hf_ready === 1'b0, "R1", "ready at reset", hf_ready, 0);
    chk(hf_active === 1'b0, "R1", "active at reset", hf_active, 0);
    track(1'b0, "R1");
    strobe(128, "R11");

    step(1);
    hf_sel_req = 1'b1;
    step(20);
    chk(hf_active === 1'b0, "R5", "select ignored while disabled", hf_active, 0);
    chk(hf_osc_en === 1'b0, "R5", "osc untouched by select", hf_osc_en, 0);

    hf_en_req = 1'b1;
    wait_ready("R3");
    chk(hf_active === 1'b0, "R5", "still pending at ready edge", hf_active, 0);
    wait_active(1'b1, "R5");
    track(1'b1, "R6");
    strobe(16, "R11");

    step(1);
    hf_sel_req = 1'b0;
    wait_active(1'b0, "R8");
    chk(hf_osc_en === 1'b1, "R8", "osc kept on after deselect", hf_osc_en, 1);
    track(1'b0, "R6");
    step(10);
    chk(hf_ready === 1'b1, "R8", "ready kept after deselect", hf_ready, 1);

    hf_en_req = 1'b0;
    step(1);
    chk(hf_osc_en === 1'b0, "R10", "osc off next edge", hf_osc_en, 0);
    chk(hf_ready === 1'b0, "R4", "ready cleared on off", hf_ready, 0);

    hf_sel_req = 1'b1; hf_en_req = 1'b1;
    wait_ready("R3");
    wait_active(1'b1, "R5");
    step(1);
    hf_en_req = 1'b0;
    step(1);
    chk(hf_osc_en === 1'b1, "R9", "osc held while fast in use", hf_osc_en, 1);
    begin
      int n = 0;
      while (hf_osc_en === 1'b1 && n < 10) begin
        chk(hf_osc_en === 1'b1 || hf_active === 1'b0, "R9", "held until slow", hf_active, 0);
        step(1); n++;
      end
      chk(hf_osc_en === 1'b0, "R9", "osc released after switch back", hf_osc_en, 0);
      chk(hf_active === 1'b0, "R9", "slow in use when released", hf_active, 0);
    end
    chk(hf_ready === 1'b0, "R4", "ready cleared after deferred off", hf_ready, 0);
    track(1'b0, "R6");

    hf_sel_req = 1'b0;
    hf_en_req = 1'b1;
    step(100);
    chk(hf_ready === 1'b0, "R3", "not ready mid-count", hf_ready, 0);
    hf_en_req = 1'b0;
    step(1);
    chk(hf_osc_en === 1'b0, "R10", "osc off mid-count", hf_osc_en, 0);
    hf_en_req = 1'b1;
    wait_ready("R4");

    step(2);
    chk(glitches == 0, "R7", "short sys_clk pulses", glitches, 0);
    chk(osc_viol == 0, "R9", "osc off while fast active", osc_viol, 0);
    chk(early == 0, "R5", "fast selected too early", early, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule